// File: doc/BRIEF.md
# Modulo Timer Base Counter

This block is the shared time base of a timer unit. It holds a count register that advances on a selectable tick source. The tick can come from the bus clock, from a fixed-rate enable pulse, or from rising edges of an external clock input that is synchronised to the bus clock. A fourth setting stops the counter. A modulus register sets the terminal count. A mode bit chooses one of two counting modes:

- a saw-tooth that wraps back to zero;
- a triangle that climbs to the terminal count and descends to zero again. This triangle is the base for centre-aligned waveforms.

A sticky overflow flag marks each period. When its enable bit is set, the flag drives a level interrupt request. Software controls the block through a small register port with three registers: control/status, modulus and count. The count value is also exported for capture, compare and waveform channels, which are not part of this block. Counting pauses while a debug halt or a stop-mode request is active.

Top module: `modtimer_core`

## Requirements
- R1: After reset the count reads 0x0000, the control word reads 0x0000 and irq_o is low. Clock select 00 (the reset value) means no tick, so the count holds.
- R2: The clock select is control bits [1:0].
  - 01 advances on every bus clock.
  - 10 advances on each cycle where fix_tick_i is high.
  - 11 advances once per rising edge of ext_clk_i. The count changes at the third rising bus clock edge after the input rises. The input must stay at or below a quarter of the bus clock rate.
- R3: With control bit 2 clear (up mode), the count advances by one per tick from 0x0000 to the terminal count, then returns to 0x0000. The overflow flag (control bit 7) is set on that step back to 0x0000.
- R4: A modulus of 0x0000 gives a terminal count of 0xFFFF. Any other modulus value is itself the terminal count.
- R5: With control bit 2 set (up/down mode), the count goes 0, 1, …, T, T−1, …, 1, 0, 1, … . Each endpoint lasts exactly one tick.
- R6: In up/down mode the overflow flag is set on the tick that takes the count from T down to T−1. It is not set at the bottom turn.
- R7: irq_o is high exactly while the overflow flag is 1 and the interrupt enable (control bit 3) is 1.
- R8: The overflow flag clears only through a two-step sequence: a control read (reg_re_i with address 0) while the flag is 1, then a control write (address 0) with bit 7 at 0. The following cases leave the flag at 1:
  - a clearing write with no read before it;
  - any other control write, which disarms the clear;
  - an overflow in the same cycle as the clearing write, which wins.
- R9: While dbg_halt_i or stop_i is high, the count and direction hold. Counting resumes from the held value when both inputs are low.
- R10: A write to the count register (address 2) sets the count to 0x0000 and the direction to upward, whatever data is written. This takes priority over a tick in the same cycle.
- R11: Writes to the modulus (address 1) and to the mode bit take effect from the next tick, with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; arms the flag clear |
| reg_addr_i | input | 2 | 0 control/status, 1 modulus, 2 count |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| fix_tick_i | input | 1 | Fixed-rate tick enable |
| ext_clk_i | input | 1 | External clock, asynchronous |
| dbg_halt_i | input | 1 | Debug halt, freezes counting |
| stop_i | input | 1 | Stop mode, freezes counting |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | Overflow interrupt request (level) |

## Verification
Register writes and the bus, fixed and halt gating all act at the next rising edge. The bench therefore drives every stimulus just after a falling edge and checks the count and flag at the following falling edge, one cycle later. The external clock path goes through two synchroniser flops and an edge register. Its checks expect the count to stay put at the first and second falling edges after the input rises and to move at the third. For the sweeps, each tick index k is converted to an expected count: k mod (T+1) in up mode, and the folded value of k mod 2T in up/down mode. The flag is expected from tick T+1 onward.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MOD   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;

  // control/status bit positions
  localparam int unsigned SEL_LSB  = 0;
  localparam int unsigned MODE_BIT = 2;
  localparam int unsigned IE_BIT   = 3;
  localparam int unsigned FLAG_BIT = 7;

  typedef enum logic [1:0] {
    CLK_OFF = 2'b00,
    CLK_BUS = 2'b01,
    CLK_FIX = 2'b10,
    CLK_EXT = 2'b11
  } clk_sel_e;

endpackage

// File: rtl/modtimer_rstsync.sv
module modtimer_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/modtimer_clksel.sv
module modtimer_clksel
  import modtimer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_sel_e sel_i,
  input  logic     fix_tick_i,
  input  logic     ext_clk_i,
  input  logic     halt_i,
  output logic     tick_o
);
  // synchroniser stages plus one history stage for edge detection
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] ext_q;
  logic [CHAIN-1:0] ext_d;
  logic             ext_rise;
  logic             raw_tick;

  always_comb ext_d = {ext_q[CHAIN-2:0], ext_clk_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= ext_d;
  end

  assign ext_rise = ext_q[CHAIN-2] & ~ext_q[CHAIN-1];

  always_comb begin
    unique case (sel_i)
      CLK_BUS: raw_tick = 1'b1;
      CLK_FIX: raw_tick = fix_tick_i;
      CLK_EXT: raw_tick = ext_rise;
      default: raw_tick = 1'b0;
    endcase
  end

  assign tick_o = raw_tick & ~halt_i;
endmodule

// File: rtl/modtimer_counter.sv
module modtimer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             updown_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] term_o,
  output logic             dir_up_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic [CNT_W-1:0] term;

  assign term = (mod_i == '0) ? '1 : mod_i;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    ovf_o = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (tick_i) begin
      if (!updown_i) begin
        up_d = 1'b1;
        if (cnt_q == term) begin
          cnt_d = '0;
          ovf_o = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (up_q) begin
        if (cnt_q >= term) begin
          cnt_d = cnt_q - ONE;
          up_d  = 1'b0;
          ovf_o = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = ONE;
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign count_o  = cnt_q;
  assign term_o   = term;
  assign dir_up_o = up_q;
endmodule

// File: rtl/modtimer_regs.sv
module modtimer_regs
  import modtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              ovf_i,
  output logic [CNT_W-1:0]  rdata_o,
  output clk_sel_e          sel_o,
  output logic              updown_o,
  output logic              ie_o,
  output logic [CNT_W-1:0]  mod_o,
  output logic              flag_o,
  output logic              ctrl_wr_o,
  output logic              cnt_wr_o
);
  clk_sel_e         sel_q, sel_d;
  logic             updown_q, updown_d;
  logic             ie_q, ie_d;
  logic [CNT_W-1:0] mod_q, mod_d;
  logic             flag_q, flag_d;
  logic             arm_q, arm_d;
  logic             ctrl_wr, mod_wr, ctrl_rd, clr_req;

  assign ctrl_wr = we_i && (addr_i == ADDR_CTRL);
  assign mod_wr  = we_i && (addr_i == ADDR_MOD);
  assign ctrl_rd = re_i && (addr_i == ADDR_CTRL);
  assign clr_req = ctrl_wr && arm_q && !wdata_i[FLAG_BIT];

  always_comb begin
    sel_d    = sel_q;
    updown_d = updown_q;
    ie_d     = ie_q;
    mod_d    = mod_q;
    if (ctrl_wr) begin
      sel_d    = clk_sel_e'(wdata_i[SEL_LSB+1:SEL_LSB]);
      updown_d = wdata_i[MODE_BIT];
      ie_d     = wdata_i[IE_BIT];
    end
    if (mod_wr) mod_d = wdata_i;
  end

  // a fresh overflow outranks a clear in the same cycle
  always_comb begin
    if (ovf_i)        flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_comb begin
    if (!flag_d)               arm_d = 1'b0;
    else if (ctrl_wr)          arm_d = 1'b0;
    else if (ctrl_rd && flag_q) arm_d = 1'b1;
    else                       arm_d = arm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= CLK_OFF;
      updown_q <= 1'b0;
      ie_q     <= 1'b0;
      mod_q    <= '0;
      flag_q   <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      updown_q <= updown_d;
      ie_q     <= ie_d;
      mod_q    <= mod_d;
      flag_q   <= flag_d;
      arm_q    <= arm_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[SEL_LSB+1:SEL_LSB] = sel_q;
        rdata_o[MODE_BIT]          = updown_q;
        rdata_o[IE_BIT]            = ie_q;
        rdata_o[FLAG_BIT]          = flag_q;
      end
      ADDR_MOD:   rdata_o = mod_q;
      ADDR_COUNT: rdata_o = count_i;
      default:    rdata_o = '0;
    endcase
  end

  assign sel_o     = sel_q;
  assign updown_o  = updown_q;
  assign ie_o      = ie_q;
  assign mod_o     = mod_q;
  assign flag_o    = flag_q;
  assign ctrl_wr_o = ctrl_wr;
  assign cnt_wr_o  = we_i && (addr_i == ADDR_COUNT);
endmodule

// File: rtl/modtimer_core.sv
module modtimer_core
  import modtimer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic              fix_tick_i,
  input  logic              ext_clk_i,
  input  logic              dbg_halt_i,
  input  logic              stop_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  clk_sel_e         sel;
  logic             updown, ie, flag, ctrl_wr, cnt_wr, tick, ovf, dir_up;
  logic [CNT_W-1:0] mod, term;

  modtimer_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  modtimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .we_i      (reg_we_i),
    .re_i      (reg_re_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .count_i   (count_o),
    .ovf_i     (ovf),
    .rdata_o   (reg_rdata_o),
    .sel_o     (sel),
    .updown_o  (updown),
    .ie_o      (ie),
    .mod_o     (mod),
    .flag_o    (flag),
    .ctrl_wr_o (ctrl_wr),
    .cnt_wr_o  (cnt_wr)
  );

  modtimer_clksel #(.SYNC_STAGES(SYNC_STAGES)) u_clksel (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sel_i      (sel),
    .fix_tick_i (fix_tick_i),
    .ext_clk_i  (ext_clk_i),
    .halt_i     (dbg_halt_i | stop_i),
    .tick_o     (tick)
  );

  modtimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .tick_i   (tick),
    .updown_i (updown),
    .clear_i  (cnt_wr),
    .mod_i    (mod),
    .count_o  (count_o),
    .term_o   (term),
    .dir_up_o (dir_up),
    .ovf_o    (ovf)
  );

  assign irq_o = flag & ie;
endmodule

// File: rtl/modtimer_checker.sv
module modtimer_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             updown,
  input logic             dir_up,
  input logic             flag,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic [1:0]       sel,
  input logic             dbg_halt_i,
  input logic             stop_i,
  input logic [CNT_W-1:0] term,
  input logic [CNT_W-1:0] count_o
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 2'b00) && !cnt_wr |=> $stable(count_o)); // R1

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !updown && !cnt_wr |=>
      (count_o == CNT_W'($past(count_o) + CNT_W'(1))) || (count_o == '0)); // R3

  AST_BOTTOM_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && updown && !dir_up && (count_o == '0) && !cnt_wr |=>
      (count_o == CNT_W'(1)) && dir_up); // R5

  AST_TOP_TURN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && updown && dir_up && (count_o == term) && !cnt_wr |=>
      flag && !dir_up && (count_o == CNT_W'($past(count_o) - CNT_W'(1)))); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !ctrl_wr |=> flag); // R8

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_halt_i || stop_i) && !cnt_wr |=> $stable(count_o) && $stable(dir_up)); // R9

  AST_COUNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (count_o == '0) && dir_up); // R10
endmodule

bind modtimer_core modtimer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .tick       (tick),
  .updown     (updown),
  .dir_up     (dir_up),
  .flag       (flag),
  .ctrl_wr    (ctrl_wr),
  .cnt_wr     (cnt_wr),
  .sel        (sel),
  .dbg_halt_i (dbg_halt_i),
  .stop_i     (stop_i),
  .term       (term),
  .count_o    (count_o)
);

// File: tb/modtimer_core_test.sv
module modtimer_core_test;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MOD  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  // control word: [1:0] clock select, [2] up/down, [3] irq enable, [7] flag
  localparam logic [15:0] S_BUS = 16'h0001;
  localparam logic [15:0] S_FIX = 16'h0002;
  localparam logic [15:0] S_EXT = 16'h0003;
  localparam logic [15:0] M_UD  = 16'h0004;
  localparam logic [15:0] B_IE  = 16'h0008;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        fix = 1'b0, ext = 1'b0, dbg = 1'b0, stp = 1'b0;
  logic [15:0] count;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modtimer_core uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fix_tick_i(fix), .ext_clk_i(ext),
    .dbg_halt_i(dbg), .stop_i(stp),
    .count_o(count), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = A_CTRL;
  endtask

  task automatic rd_arm();
    re = 1'b1; addr = A_CTRL;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_cnt(input bit ud, input int m, input int k);
    int p;
    if (!ud) return k % (m + 1);
    p = k % (2 * m);
    return (p <= m) ? p : 2 * m - p;
  endfunction

  function automatic bit flag_now();
    return rdata[7];
  endfunction

  task automatic restart(input logic [15:0] m, input logic [15:0] ctrl);
    wr(A_CTRL, 16'h0000);
    wr(A_MOD, m);
    wr(A_CNT, 16'h0000);
    rd_arm();
    wr(A_CTRL, 16'h0000);
    wr(A_CTRL, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    int pulses;
    step(2);
    rst_n = 1'b1;
    step(4);

    // R1 reset state, clock off
    chk(count == 16'h0, "R1 count", count, 0);
    chk(rdata == 16'h0, "R1 ctrl", rdata, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    step(5);
    chk(count == 16'h0, "R1 idle", count, 0);

    // R3 R5 R6 sweep over modulus and mode
    for (int ud = 0; ud < 2; ud++) begin
      for (int m = 1; m <= 5; m++) begin
        restart(16'(m), S_BUS | (ud != 0 ? M_UD : 16'h0));
        chk(count == 0 && !flag_now(), "R3 R5 start", count, 0);
        for (int k = 1; k <= 4 * m + 3; k++) begin
          step(1);
          chk(count == 16'(exp_cnt(ud != 0, m, k)), ud != 0 ? "R5 count" : "R3 count",
              count, exp_cnt(ud != 0, m, k));
          chk(flag_now() == (k >= m + 1), ud != 0 ? "R6 flag" : "R3 flag",
              flag_now(), (k >= m + 1));
        end
      end
    end

    // R7 irq follows flag and enable (flag is set from the sweep)
    wr(A_CTRL, 16'h0000);
    chk(irq == 1'b0, "R7 disabled", irq, 0);
    wr(A_CTRL, B_IE);
    chk(irq == 1'b1, "R7 enabled", irq, 1);

    // R8 clear with no read first has no effect
    wr(A_CTRL, B_IE);
    chk(flag_now() == 1'b1, "R8 no-read clear", flag_now(), 1);
    rd_arm();
    wr(A_CTRL, B_IE);
    chk(flag_now() == 1'b0, "R8 armed clear", flag_now(), 0);
    chk(irq == 1'b0, "R7 cleared", irq, 0);

    // R8 overflow in the clearing cycle wins (mod 1, up: 0,1,0,...)
    restart(16'd1, S_BUS);
    step(3);
    rd_arm();
    if (count != 16'd1) step(1);
    wr(A_CTRL, S_BUS);
    chk(flag_now() == 1'b1, "R8 overflow wins", flag_now(), 1);
    rd_arm();
    if (count != 16'd0) step(1);
    wr(A_CTRL, S_BUS);
    chk(flag_now() == 1'b0, "R8 clear no overflow", flag_now(), 0);

    // R9 debug halt and stop freeze the count
    restart(16'd200, S_BUS);
    step(7);
    c = count;
    dbg = 1'b1;
    step(5);
    chk(count == 16'(c), "R9 debug hold", count, c);
    dbg = 1'b0;
    step(1);
    chk(count == 16'(c + 1), "R9 debug resume", count, c + 1);
    c = count;
    stp = 1'b1;
    step(4);
    chk(count == 16'(c), "R9 stop hold", count, c);
    stp = 1'b0;
    step(2);
    chk(count == 16'(c + 2), "R9 stop resume", count, c + 2);

    // R2 fixed-rate tick enable
    restart(16'd200, S_FIX);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      fix = 1'b1; step(1); fix = 1'b0; pulses++;
      chk(count == 16'(pulses), "R2 fixed tick", count, pulses);
      step(2);
      chk(count == 16'(pulses), "R2 fixed idle", count, pulses);
    end

    // R2 external clock: latency then edge count
    restart(16'd200, S_EXT);
    ext = 1'b1;
    step(2);
    chk(count == 16'd0, "R2 ext latency", count, 0);
    step(1);
    chk(count == 16'd1, "R2 ext first edge", count, 1);
    step(1);
    ext = 1'b0;
    for (int i = 0; i < 7; i++) begin
      step(3); ext = 1'b1; step(3); ext = 1'b0;
    end
    step(4);
    chk(count == 16'd8, "R2 ext edges", count, 8);

    // R10 count write while descending restarts upward
    restart(16'd6, S_BUS | M_UD);
    step(8);
    chk(count == 16'd4, "R5 descending", count, 4);
    wr(A_CNT, 16'h1234);
    chk(count == 16'd0, "R10 reset", count, 0);
    step(2);
    chk(count == 16'd2, "R10 upward", count, 2);

    // R11 modulus change is immediate
    restart(16'd10, S_BUS);
    step(3);
    wr(A_MOD, 16'd5);
    chk(count == 16'd4, "R11 pre", count, 4);
    step(1);
    chk(count == 16'd5, "R11 reach", count, 5);
    step(1);
    chk(count == 16'd0 && flag_now(), "R11 new wrap", count, 0);

    // R4 modulus zero runs to 0xFFFF
    restart(16'd0, S_BUS);
    step(65535);
    chk(count == 16'hFFFF && !flag_now(), "R4 top", count, 16'hFFFF);
    step(1);
    chk(count == 16'h0 && flag_now(), "R4 wrap", count, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule